// File: doc/BRIEF.md
# Dual-Channel DMA Slave with Terminal Count

This block is the peripheral end of a 16-bit processor bus. It serves two buffer sides, a host-side buffer and a device-side buffer, and gives each side a DMA channel with its own request output and acknowledge input. While a channel is enabled it holds its request high. The processor's DMA engine then moves words by pulsing the read or write strobe while the matching acknowledge is low. Each word appears as a one-cycle write or read pulse on the buffer interface of that side.

A transfer stops on whichever comes first: the external end-of-transfer input, sampled with the strobe of a DMA word, or an internal terminal count. The terminal count fires when the channel's word counter reaches the programmed limit, if the configuration enables it. When a transfer stops, the request drops, the counter clears and the enable bit clears. The channel stays idle until software enables it again.

Software uses programmed I/O. Chip select and two address lines pick one of four ports. For each side there is a data port and a write-only command port. Writing a command code to a command port selects a register. The next data-port access on that side then reads or writes that register. Without a pending command, a data-port access goes straight to that side's buffer. All effects of a strobe land on its trailing (rising) edge.

Top module: `dual_dma_slave`

## Requirements
- R1: With `cs_n` low, `addr` selects the port: 0 is the host data port, 1 the host command port, 2 the device data port and 3 the device command port. `addr[1]` picks the side (0 host, 1 device) and `addr[0]` picks command (1) or data (0). Any strobe with `cs_n` high and no granted acknowledge changes nothing.
- R2: A write to a command port latches the low byte of `din` as that side's pending command. The next data-port access on the same side consumes the command and does not reach the buffer. Code 0xA1 writes the configuration register and 0x21 reads it. Code 0xA2 writes the limit register and 0x22 reads it. Bit 7 set means write. Any other code, or a strobe whose direction does not match bit 7, reads as zero and changes no register.
- R3: In the configuration register, bit 0 is the channel enable and bit 1 is the terminal-count enable. The register reads back as {0..., tc_enable, enable}. The limit register reads back zero-extended.
- R4: `dreq[i]` is high exactly while channel i is enabled and not ended. It is low after reset.
- R5: When `dack_n[i]` is low, `dreq[i]` is high and a strobe completes, one word moves. A write pulses `buf_we[i]` for one cycle with `buf_wdata` equal to the strobed `din`. A read shows slice i of `buf_rdata` on `dout` while `rd_n` is low, and then pulses `buf_re[i]`. An acknowledge on a channel whose request is low is ignored. If both acknowledges are low, channel 0 wins.
- R6: The word counter advances on the trailing edge of each DMA strobe. With the terminal-count enable set, the transfer ends once the count reaches the limit. A limit of zero ends the transfer at once, so the request never rises.
- R7: If `eot_n` is low during the strobe of a DMA word, the word still moves and then that channel ends.
- R8: On any end, the request drops, the enable bit clears and the counter returns to zero. A later enable starts a fresh count.
- R9: A read of a command port returns zero and leaves any pending command in place.
- R10: A data-port access with no pending command reaches that side's buffer: a write pulses `buf_we`, and a read returns the `buf_rdata` slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 2 | Port select |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | DATA_W | Write data from the processor |
| dout | output | DATA_W | Read data to the processor |
| dack_n | input | 2 | DMA acknowledges, active low (0 host, 1 device) |
| eot_n | input | 1 | External end-of-transfer, active low |
| dreq | output | 2 | DMA requests (0 host, 1 device) |
| buf_we | output | 2 | Buffer write pulse per side |
| buf_re | output | 2 | Buffer read-advance pulse per side |
| buf_wdata | output | DATA_W | Data to the buffer |
| buf_rdata | input | 2*DATA_W | Buffer read data, side i in slice i |

## Verification
The bench keeps DATA_W at 16 and builds the block with CNT_W set to 4. With that width the largest limit, 15, is reached in a short run. This lets the bench check the top end of the counter along with a limit of zero and small limits. A behavioural model of the enable bits, limits and counts predicts `dreq` on every settled clock. Directed sequences check end-of-transfer ordering, acknowledge priority, command consumption and ignored accesses.

// File: rtl/dsl_pkg.sv
`timescale 1ns/1ps
package dsl_pkg;
    localparam int NCH = 2;
    localparam logic [6:0] REG_CFG = 7'h21;
    localparam logic [6:0] REG_LIM = 7'h22;

    typedef struct packed {
        logic           valid;
        logic           write;
        logic           sel;
        logic [1:0]     port;
        logic [NCH-1:0] ack;
        logic           eot;
    } bus_ev_t;

    typedef struct packed {
        logic tc_en;
        logic en;
    } cfg_t;

    function automatic logic cmd_is_write(input logic [7:0] code);
        return code[7];
    endfunction
endpackage

// File: rtl/dsl_capture.sv
`timescale 1ns/1ps
module dsl_capture
    import dsl_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic [1:0]     addr,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [NCH-1:0] dack_n,
    input  logic           eot_n,
    input  logic [DW-1:0]  din,
    output bus_ev_t        ev,
    output logic [DW-1:0]  ev_data
);
    logic           rd_q, wr_q, cs_q, eot_q;
    logic [1:0]     addr_q;
    logic [NCH-1:0] ack_q;
    logic [DW-1:0]  din_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q    <= 1'b1;
            wr_q    <= 1'b1;
            cs_q    <= 1'b1;
            eot_q   <= 1'b1;
            addr_q  <= '0;
            ack_q   <= '1;
            din_q   <= '0;
            ev      <= '0;
            ev_data <= '0;
        end else begin
            rd_q     <= rd_n;
            wr_q     <= wr_n;
            cs_q     <= cs_n;
            eot_q    <= eot_n;
            addr_q   <= addr;
            ack_q    <= dack_n;
            din_q    <= din;
            // trailing edge: low on the previous sample, high now
            ev.valid <= (!rd_q && rd_n) || (!wr_q && wr_n);
            ev.write <= !wr_q && wr_n;
            ev.sel   <= !cs_q;
            ev.port  <= addr_q;
            ev.ack   <= ~ack_q;
            ev.eot   <= !eot_q;
            ev_data  <= din_q;
        end
    end
endmodule

// File: rtl/dsl_chan.sv
`timescale 1ns/1ps
module dsl_chan
    import dsl_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr,
    input  logic [7:0]    cmd_code,
    input  logic          reg_acc,
    input  logic          reg_write,
    input  logic [CW-1:0] wdata,
    input  logic          dma_word,
    input  logic          dma_eot,
    output logic          dreq_o,
    output logic          pend_o,
    output logic [DW-1:0] rd_val_o
);
    logic [7:0]    code_q;
    logic          pend_q;
    cfg_t          cfg_q;
    logic [CW-1:0] lim_q, cnt_q;
    logic          hit, wr_cfg, wr_lim, end_now;

    assign hit     = cfg_q.en && cfg_q.tc_en && (cnt_q >= lim_q);
    assign wr_cfg  = reg_acc && reg_write && cmd_is_write(code_q) && (code_q[6:0] == REG_CFG);
    assign wr_lim  = reg_acc && reg_write && cmd_is_write(code_q) && (code_q[6:0] == REG_LIM);
    assign end_now = hit || (dma_word && dma_eot);
    assign dreq_o  = cfg_q.en && !hit;
    assign pend_o  = pend_q;

    always_comb begin
        rd_val_o = '0;
        if (pend_q && !cmd_is_write(code_q)) begin
            if (code_q[6:0] == REG_CFG)      rd_val_o = DW'({cfg_q.tc_en, cfg_q.en});
            else if (code_q[6:0] == REG_LIM) rd_val_o = DW'(lim_q);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            pend_q <= 1'b0;
            cfg_q  <= '0;
            lim_q  <= '0;
            cnt_q  <= '0;
        end else begin
            if (cmd_wr) begin
                code_q <= cmd_code;
                pend_q <= 1'b1;
            end else if (reg_acc) begin
                pend_q <= 1'b0;
            end
            if (wr_lim) lim_q <= wdata;
            if (wr_cfg) begin
                cfg_q.en    <= wdata[0];
                cfg_q.tc_en <= wdata[1];
                cnt_q       <= '0;
            end else if (end_now) begin
                cfg_q.en <= 1'b0;
                cnt_q    <= '0;
            end else if (dma_word) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R7: a word strobed with end-of-transfer ends the channel
    p_eot_ends_r7: assert property (@(posedge clk) disable iff (rst)
        (dma_word && dma_eot) |=> !dreq_o);
    // R6: the word that brings the count to the limit drops the request
    p_tc_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (dma_word && cfg_q.tc_en && ((cnt_q + 1'b1) == lim_q)) |=> !dreq_o);
    // R8: whenever the enable falls, the count is back at zero
    p_clr_on_end_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_q.en) |-> (cnt_q == '0));
endmodule

// File: rtl/dual_dma_slave.sv
`timescale 1ns/1ps
module dual_dma_slave
    import dsl_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs_n,
    input  logic [1:0]            addr,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic [DATA_W-1:0]     din,
    output logic [DATA_W-1:0]     dout,
    input  logic [1:0]            dack_n,
    input  logic                  eot_n,
    output logic [1:0]            dreq,
    output logic [1:0]            buf_we,
    output logic [1:0]            buf_re,
    output logic [DATA_W-1:0]     buf_wdata,
    input  logic [2*DATA_W-1:0]   buf_rdata
);
    bus_ev_t                      ev;
    logic [DATA_W-1:0]            ev_data;
    logic [NCH-1:0]               pend_w, grant;
    logic [NCH-1:0][DATA_W-1:0]   rdv_w;
    logic                         pio;

    dsl_capture #(.DW(DATA_W)) u_cap (
        .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .dack_n(dack_n), .eot_n(eot_n), .din(din), .ev(ev), .ev_data(ev_data)
    );

    // lowest channel with a live request takes the acknowledged word
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < NCH; i++) begin
            if (!taken && ev.valid && ev.ack[i] && dreq[i]) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    assign pio       = ev.valid && ev.sel && (grant == '0);
    assign buf_wdata = ev_data;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam logic SIDE = (g != 0);
        logic on_side, cmd_hit, data_hit, buf_hit;
        assign on_side  = pio && (ev.port[1] == SIDE);
        assign cmd_hit  = on_side && ev.port[0];
        assign data_hit = on_side && !ev.port[0];
        assign buf_hit  = grant[g] || (data_hit && !pend_w[g]);
        assign buf_we[g] = buf_hit && ev.write;
        assign buf_re[g] = buf_hit && !ev.write;

        dsl_chan #(.DW(DATA_W), .CW(CNT_W)) u_chan (
            .clk(clk), .rst(rst),
            .cmd_wr(cmd_hit && ev.write), .cmd_code(ev_data[7:0]),
            .reg_acc(data_hit && pend_w[g]), .reg_write(ev.write),
            .wdata(ev_data[CNT_W-1:0]),
            .dma_word(grant[g]), .dma_eot(ev.eot),
            .dreq_o(dreq[g]), .pend_o(pend_w[g]), .rd_val_o(rdv_w[g])
        );
    end

    always_comb begin
        logic found;
        found = 1'b0;
        dout  = '0;
        if (!rd_n) begin
            for (int i = 0; i < NCH; i++) begin
                if (!found && !dack_n[i] && dreq[i]) begin
                    dout  = buf_rdata[i*DATA_W +: DATA_W];
                    found = 1'b1;
                end
            end
            if (!found && !cs_n && !addr[0]) begin
                if (pend_w[addr[1]]) dout = rdv_w[addr[1]];
                else                 dout = buf_rdata[int'(addr[1])*DATA_W +: DATA_W];
            end
        end
    end

    // R5: at most one buffer side moves a word per strobe
    p_one_side_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(buf_we | buf_re));
    // R9: a command port read drives zero
    p_cmd_rd_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (!rd_n && !cs_n && addr[0] && (&dack_n)) |-> (dout == '0));
endmodule

// File: tb/dual_dma_slave_test.sv
`timescale 1ns/1ps
module dual_dma_slave_test;
    localparam int DW = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, eot_n = 1'b1;
    logic [1:0]    addr = '0, dack_n = 2'b11;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout, buf_wdata;
    logic [1:0]    dreq, buf_we, buf_re;
    logic [2*DW-1:0] buf_rdata = {16'h1234, 16'hC0DE};

    int total = 0, bad = 0;
    bit settled = 0, finished = 0;
    int m_en[2], m_tc[2], m_lim[2], m_cnt[2];
    int we_cnt[2], re_cnt[2];
    logic [DW-1:0] last_wd[2];

    dual_dma_slave #(.DATA_W(DW), .CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .din(din), .dout(dout), .dack_n(dack_n), .eot_n(eot_n), .dreq(dreq),
        .buf_we(buf_we), .buf_re(buf_re), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit mdreq(input int c);
        return (m_en[c] != 0) && !((m_tc[c] != 0) && (m_cnt[c] >= m_lim[c]));
    endfunction

    function automatic void mnorm(input int c);
        if (m_en[c] != 0 && m_tc[c] != 0 && m_cnt[c] >= m_lim[c]) begin
            m_en[c] = 0;
            m_cnt[c] = 0;
        end
    endfunction

    // reference comparison of the requests on every settled clock (R4)
    always @(negedge clk) begin
        if (settled && !rst && !finished)
            check(dreq == {mdreq(1), mdreq(0)}, "R4 dreq", dreq, {mdreq(1), mdreq(0)});
    end

    always @(posedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 2; i++) begin
                if (buf_we[i]) begin we_cnt[i]++; last_wd[i] = buf_wdata; end
                if (buf_re[i]) re_cnt[i]++;
            end
        end
    end

    task automatic do_bus(input bit wr, input bit cs, input logic [1:0] a, input logic [1:0] ack,
                          input bit eot, input logic [DW-1:0] d, output logic [DW-1:0] q);
        settled = 0;
        @(negedge clk);
        cs_n = !cs; addr = a; dack_n = ~ack; eot_n = !eot; din = d;
        if (wr) wr_n = 1'b0; else rd_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        q = dout;
        rd_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1; dack_n = 2'b11; eot_n = 1'b1;
    endtask

    task automatic reg_wr(input int side, input logic [6:0] id, input logic [DW-1:0] v);
        logic [DW-1:0] q;
        do_bus(1, 1, {side[0], 1'b1}, 2'b00, 0, {8'h00, 1'b1, id}, q);
        do_bus(1, 1, {side[0], 1'b0}, 2'b00, 0, v, q);
        if (id == 7'h21) begin m_en[side] = v[0]; m_tc[side] = v[1]; m_cnt[side] = 0; end
        if (id == 7'h22) m_lim[side] = v & 16'h000F;
        mnorm(side);
        settled = 1;
    endtask

    task automatic reg_rd(input int side, input logic [7:0] code, output logic [DW-1:0] q);
        logic [DW-1:0] qq;
        do_bus(1, 1, {side[0], 1'b1}, 2'b00, 0, {8'h00, code}, qq);
        do_bus(0, 1, {side[0], 1'b0}, 2'b00, 0, '0, q);
        settled = 1;
    endtask

    task automatic dma(input int ch, input bit wr, input bit eot, input logic [DW-1:0] d,
                       output logic [DW-1:0] q);
        bit live;
        live = mdreq(ch);
        do_bus(wr, 0, 2'b00, 2'(1 << ch), eot, d, q);
        if (live) begin
            m_cnt[ch]++;
            if (eot) begin m_en[ch] = 0; m_cnt[ch] = 0; end
            mnorm(ch);
        end
        settled = 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] q;
        int w0, r1;
        for (int i = 0; i < 2; i++) begin
            m_en[i] = 0; m_tc[i] = 0; m_lim[i] = 0; m_cnt[i] = 0; we_cnt[i] = 0; re_cnt[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        settled = 1;
        // reset state
        check(dreq == 2'b00, "R4 reset dreq", dreq, 0);
        check(dout == '0, "R4 reset dout", dout, 0);
        check(buf_we == 2'b00, "R4 reset buf_we", buf_we, 0);

        // R3 enable and readback
        reg_wr(0, 7'h21, 16'h0001);
        check(dreq[0] == 1'b1, "R4 enable raises dreq", dreq[0], 1);
        reg_rd(0, 8'h21, q);
        check(q == 16'h0001, "R3 cfg readback", q, 1);

        // R9 command port read: zero, pending command survives
        do_bus(1, 1, 2'b01, 2'b00, 0, 16'h0021, q);
        do_bus(0, 1, 2'b01, 2'b00, 0, '0, q);
        check(q == '0, "R9 host cmd port read", q, 0);
        do_bus(0, 1, 2'b11, 2'b00, 0, '0, q);
        check(q == '0, "R9 device cmd port read", q, 0);
        do_bus(0, 1, 2'b00, 2'b00, 0, '0, q);
        settled = 1;
        check(q == 16'h0001, "R9 pending read kept", q, 1);

        // R5 host DMA write
        w0 = we_cnt[0];
        dma(0, 1, 0, 16'hBEEF, q);
        check(we_cnt[0] == w0 + 1, "R5 dma write pulse", we_cnt[0], w0 + 1);
        check(last_wd[0] == 16'hBEEF, "R5 dma write data", last_wd[0], 16'hBEEF);

        // R6 terminal count of 3
        reg_wr(0, 7'h22, 16'h0003);
        reg_wr(0, 7'h21, 16'h0003);
        dma(0, 1, 0, 16'h0001, q);
        dma(0, 1, 0, 16'h0002, q);
        check(dreq[0] == 1'b1, "R6 dreq before limit", dreq[0], 1);
        dma(0, 1, 0, 16'h0003, q);
        check(dreq[0] == 1'b0, "R6 dreq at limit", dreq[0], 0);
        reg_rd(0, 8'h21, q);
        check(q == 16'h0002, "R8 enable cleared at limit", q, 2);
        reg_rd(0, 8'h22, q);
        check(q == 16'h0003, "R3 limit readback", q, 3);

        // R5/R7 device DMA reads, external end
        reg_wr(1, 7'h21, 16'h0001);
        r1 = re_cnt[1];
        dma(1, 0, 0, '0, q);
        check(q == 16'h1234, "R5 dma read data", q, 16'h1234);
        check(re_cnt[1] == r1 + 1, "R5 dma read pulse", re_cnt[1], r1 + 1);
        dma(1, 0, 1, '0, q);
        check(q == 16'h1234, "R7 word moves with eot", q, 16'h1234);
        check(dreq[1] == 1'b0, "R7 eot ends channel", dreq[1], 0);
        reg_rd(1, 8'h21, q);
        check(q == 16'h0000, "R8 enable cleared by eot", q, 0);

        // R8 fresh count after end
        reg_wr(1, 7'h22, 16'h0002);
        reg_wr(1, 7'h21, 16'h0001);
        dma(1, 1, 1, 16'h0007, q);
        reg_wr(1, 7'h21, 16'h0003);
        dma(1, 1, 0, 16'h0008, q);
        check(dreq[1] == 1'b1, "R8 count restarted", dreq[1], 1);
        dma(1, 1, 0, 16'h0009, q);
        check(dreq[1] == 1'b0, "R8 ends after two", dreq[1], 0);

        // R6 limit zero
        reg_wr(0, 7'h22, 16'h0000);
        reg_wr(0, 7'h21, 16'h0003);
        check(dreq[0] == 1'b0, "R6 limit zero", dreq[0], 0);
        reg_rd(0, 8'h21, q);
        check(q == 16'h0002, "R6 limit zero clears enable", q, 2);

        // R5 ack ignored when request low
        w0 = we_cnt[0];
        dma(0, 1, 0, 16'h4444, q);
        check(we_cnt[0] == w0, "R5 ack without request", we_cnt[0], w0);

        // R1 chip select high ignored
        do_bus(1, 0, 2'b01, 2'b00, 0, 16'h00A1, q);
        do_bus(1, 0, 2'b00, 2'b00, 0, 16'h0001, q);
        settled = 1;
        check(dreq[0] == 1'b0, "R1 cs high ignored", dreq[0], 0);
        check(we_cnt[0] == w0, "R1 cs high no buffer", we_cnt[0], w0);

        // R10 buffer access without command
        do_bus(1, 1, 2'b00, 2'b00, 0, 16'h5A5A, q);
        check(we_cnt[0] == w0 + 1, "R10 pio buffer write", we_cnt[0], w0 + 1);
        check(last_wd[0] == 16'h5A5A, "R10 pio buffer data", last_wd[0], 16'h5A5A);
        do_bus(0, 1, 2'b10, 2'b00, 0, '0, q);
        settled = 1;
        check(q == 16'h1234, "R10 pio buffer read", q, 16'h1234);

        // R2 direction mismatch and unknown code
        reg_rd(0, 8'hA1, q);
        check(q == '0, "R2 read with write code", q, 0);
        w0 = we_cnt[0];
        do_bus(1, 1, 2'b01, 2'b00, 0, 16'h0021, q);
        do_bus(1, 1, 2'b00, 2'b00, 0, 16'h0001, q);
        settled = 1;
        check(dreq[0] == 1'b0, "R2 write with read code", dreq[0], 0);
        check(we_cnt[0] == w0, "R2 command access not buffered", we_cnt[0], w0);
        reg_rd(0, 8'h55, q);
        check(q == '0, "R2 unknown code", q, 0);

        // R1/R2 sides independent
        do_bus(1, 1, 2'b11, 2'b00, 0, 16'h00A1, q);
        w0 = we_cnt[0];
        do_bus(1, 1, 2'b00, 2'b00, 0, 16'h0001, q);
        settled = 1;
        check(we_cnt[0] == w0 + 1 && dreq == 2'b00, "R1 host data ignores device command", dreq, 0);
        do_bus(1, 1, 2'b10, 2'b00, 0, 16'h0001, q);
        m_en[1] = 1; m_tc[1] = 0; m_cnt[1] = 0;
        settled = 1;
        check(dreq[1] == 1'b1, "R2 device command kept", dreq[1], 1);

        // R5 both acks: channel 0 wins
        reg_wr(0, 7'h21, 16'h0001);
        w0 = we_cnt[0];
        r1 = we_cnt[1];
        do_bus(1, 0, 2'b00, 2'b11, 0, 16'h6666, q);
        m_cnt[0]++;
        settled = 1;
        check(we_cnt[0] == w0 + 1 && we_cnt[1] == r1, "R5 priority", we_cnt[1], r1);

        // R6 largest limit
        reg_wr(0, 7'h22, 16'h000F);
        reg_wr(0, 7'h21, 16'h0003);
        for (int k = 0; k < 14; k++) dma(0, 1, 0, 16'(k), q);
        check(dreq[0] == 1'b1, "R6 max limit minus one", dreq[0], 1);
        dma(0, 1, 0, 16'h00FF, q);
        check(dreq[0] == 1'b0, "R6 max limit reached", dreq[0], 0);

        repeat (4) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule